// File: doc/BRIEF.md
# Split-Transaction OUT Payload Sequencer

This block holds the running state of one full-speed isochronous OUT transfer that a high-speed host sends as a chain of start-split payloads. Software loads the transfer in a single cycle. The load carries two 4K-aligned page bases, a 12-bit byte offset, a page-select bit, a starting position tag, the number of start-splits and the total byte count. From that moment the block offers one payload at a time. Each payload has a 32-bit physical start address, a byte length and a position tag.

A downstream engine acknowledges each payload once it has been sent. The block then moves the offset forward and crosses from the first page to the second when the offset runs past the end of a page. It also counts down the start-splits and switches the tag to mid or end. When the last payload is acknowledged, the block issues a one-cycle retire pulse and goes idle. It does not write the final offset back. A load whose count is out of range is refused and flagged. A payload that would need a second page crossing stops the transfer and is also flagged.

Top module: `ss_out_seq`

## Requirements
- R1: A load (`ld_valid`=1) with `ld_count` in 1..6 makes `pl_req` high in the next cycle and captures every load field. `pl_req` stays high until the transfer retires, aborts or is reloaded.
- R2: While `pl_req` is high, `pl_addr` equals the selected 20-bit page base in bits 31..12 and the current 12-bit offset in bits 11..0. Page base 1 is selected when the page-select bit is 1, and page base 0 when it is 0.
- R3: While `pl_req` is high, `pl_len` equals the remaining byte count, capped at 188.
- R4: An acknowledge adds `pl_len` to the offset. When the sum is 4096 or more and page-select is 0, page-select becomes 1 and the offset becomes the sum minus 4096.
- R5: Each accepted acknowledge lowers the start-split count by one. While active, the count stays within 1..6.
- R6: A load with `ld_count` equal to 0 or greater than 6 raises `ld_err` for exactly the next cycle and leaves all transfer state unchanged.
- R7: `pl_pos` encodes the position as 00 all, 01 begin, 10 mid and 11 end. The first payload carries the loaded code. After an acknowledge that leaves a count c greater than 0, the code becomes 11 if c is 1 and 10 otherwise.
- R8: An acknowledge while the count is 1 raises `retire` for exactly one cycle, in the next cycle, with `pl_req` low from then on.
- R9: An acknowledge whose offset sum reaches 4096 while page-select is already 1 raises `cross_err` for one cycle, drops `pl_req`, and does not raise `retire`.
- R10: A synchronous active-high `rst` clears the active flag, the count, the remaining bytes, the page bases, the offset and the page-select bit. It also holds `ld_err`, `retire` and `cross_err` low.
- R11: `pl_ack` has no effect while `pl_req` is low. A load in the same cycle as an acknowledge takes priority, and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load strobe for a new transfer |
| ld_page0 | input | 20 | Page base 0, address bits 31..12 |
| ld_page1 | input | 20 | Page base 1, address bits 31..12 |
| ld_offset | input | 12 | Starting byte offset in the selected page |
| ld_psel | input | 1 | Starting page select (0 = base 0, 1 = base 1) |
| ld_pos | input | 2 | Starting position code |
| ld_count | input | 3 | Number of start-splits (1..6 valid) |
| ld_bytes | input | 11 | Total bytes of the transfer |
| ld_err | output | 1 | One-cycle flag for a refused load |
| pl_req | output | 1 | A payload is being offered (transfer active) |
| pl_addr | output | 32 | Physical start address of the payload |
| pl_len | output | 8 | Payload length in bytes |
| pl_pos | output | 2 | Payload position code |
| pl_ack | input | 1 | Payload sent; advance to the next |
| retire | output | 1 | One-cycle pulse when the last payload is acknowledged |
| cross_err | output | 1 | One-cycle pulse when a second page crossing is needed |

## Verification
Several properties are checked on every cycle. The payload length never exceeds 188. The count stays within 1..6 while active. A refused load is always followed by `ld_err`. Once page-select is set, it stays set for the life of the transfer. Retire and abort leave the block idle, and idle acknowledges have no effect. Other behaviour can only be shown by the bench's reference model driven through concrete scenarios. This covers the exact addresses across a page crossing, including a sum of exactly 4096. It also covers the begin/mid/end order for different counts, the retire timing after the last acknowledge, and load priority over a simultaneous acknowledge.

// File: rtl/ss_out_seq.sv
module ss_out_seq #(
  parameter int PG_W    = 20,
  parameter int OFF_W   = 12,
  parameter int REM_W   = 11,
  parameter int CNT_W   = 3,
  parameter int MAX_CNT = 6,
  parameter int MAX_PAY = 188
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  logic [PG_W-1:0]       ld_page0,
  input  logic [PG_W-1:0]       ld_page1,
  input  logic [OFF_W-1:0]      ld_offset,
  input  logic                  ld_psel,
  input  logic [1:0]            ld_pos,
  input  logic [CNT_W-1:0]      ld_count,
  input  logic [REM_W-1:0]      ld_bytes,
  output logic                  ld_err,
  output logic                  pl_req,
  output logic [PG_W+OFF_W-1:0] pl_addr,
  output logic [7:0]            pl_len,
  output logic [1:0]            pl_pos,
  input  logic                  pl_ack,
  output logic                  retire,
  output logic                  cross_err
);
  localparam int LEN_W = 8;
  localparam logic [LEN_W-1:0] PAY_CAP = LEN_W'(MAX_PAY);
  localparam logic [1:0] POS_MID = 2'b10;
  localparam logic [1:0] POS_END = 2'b11;

  logic              active;
  logic [PG_W-1:0]   page0, page1;
  logic [OFF_W-1:0]  off;
  logic              psel;
  logic [1:0]        pos;
  logic [CNT_W-1:0]  cnt;
  logic [REM_W-1:0]  rem;

  logic              ld_ok, fire, wrap, last;
  logic [OFF_W:0]    sum;
  logic [CNT_W-1:0]  cnt_m1;

  assign ld_ok  = (ld_count != '0) && (ld_count <= CNT_W'(MAX_CNT));
  assign pl_len = (rem > REM_W'(MAX_PAY)) ? PAY_CAP : rem[LEN_W-1:0];
  assign sum    = {1'b0, off} + (OFF_W+1)'(pl_len);
  assign wrap   = sum[OFF_W];
  assign fire   = active && pl_ack && !ld_valid;
  assign last   = (cnt == CNT_W'(1));
  assign cnt_m1 = cnt - CNT_W'(1);

  assign pl_req  = active;
  assign pl_pos  = pos;
  assign pl_addr = {psel ? page1 : page0, off};

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      page0     <= '0;
      page1     <= '0;
      off       <= '0;
      psel      <= 1'b0;
      pos       <= '0;
      cnt       <= '0;
      rem       <= '0;
      ld_err    <= 1'b0;
      retire    <= 1'b0;
      cross_err <= 1'b0;
    end else begin
      ld_err    <= 1'b0;
      retire    <= 1'b0;
      cross_err <= 1'b0;
      if (ld_valid) begin
        if (ld_ok) begin
          active <= 1'b1;
          page0  <= ld_page0;
          page1  <= ld_page1;
          off    <= ld_offset;
          psel   <= ld_psel;
          pos    <= ld_pos;
          cnt    <= ld_count;
          rem    <= ld_bytes;
        end else begin
          ld_err <= 1'b1;
        end
      end else if (fire) begin
        if (wrap && psel) begin
          active    <= 1'b0;
          cross_err <= 1'b1;
        end else begin
          off <= sum[OFF_W-1:0];
          if (wrap) psel <= 1'b1;
          rem <= rem - REM_W'(pl_len);
          cnt <= cnt_m1;
          pos <= (cnt_m1 == CNT_W'(1)) ? POS_END : POS_MID;
          if (last) begin
            active <= 1'b0;
            retire <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ss_out_seq_chk.sv
module ss_out_seq_chk #(
  parameter int CNT_W   = 3,
  parameter int MAX_CNT = 6,
  parameter int MAX_PAY = 188
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_valid,
  input logic [CNT_W-1:0] ld_count,
  input logic             pl_ack,
  input logic             pl_req,
  input logic [7:0]       pl_len,
  input logic             retire,
  input logic             ld_err,
  input logic             cross_err,
  input logic             psel,
  input logic [CNT_W-1:0] cnt
);
  assert_len_cap_R3: assert property (@(posedge clk) disable iff (rst)
    pl_req |-> (pl_len <= 8'(MAX_PAY)));

  assert_count_range_R5: assert property (@(posedge clk) disable iff (rst)
    pl_req |-> (cnt != '0 && cnt <= CNT_W'(MAX_CNT)));

  assert_load_err_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && (ld_count == '0 || ld_count > CNT_W'(MAX_CNT))) |=> ld_err);

  assert_page_once_R4: assert property (@(posedge clk) disable iff (rst)
    (pl_req && $past(pl_req) && $past(psel) && !$past(ld_valid)) |-> psel);

  assert_retire_idle_R8: assert property (@(posedge clk) disable iff (rst)
    retire |-> !pl_req);

  assert_cross_stop_R9: assert property (@(posedge clk) disable iff (rst)
    cross_err |-> (!pl_req && !retire));

  assert_idle_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (!pl_req && !ld_valid && pl_ack) |=> (!pl_req && !retire && !cross_err));
endmodule

bind ss_out_seq ss_out_seq_chk #(
  .CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .MAX_PAY(MAX_PAY)
) chk_i (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_count(ld_count),
  .pl_ack(pl_ack), .pl_req(pl_req), .pl_len(pl_len), .retire(retire),
  .ld_err(ld_err), .cross_err(cross_err), .psel(psel), .cnt(cnt)
);

// File: tb/ss_out_seq_tb_top.sv
module ss_out_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [19:0] ld_page0 = '0, ld_page1 = '0;
  logic [11:0] ld_offset = '0;
  logic        ld_psel = 1'b0;
  logic [1:0]  ld_pos = '0;
  logic [2:0]  ld_count = '0;
  logic [10:0] ld_bytes = '0;
  logic        pl_ack = 1'b0;
  logic        ld_err, pl_req, retire, cross_err;
  logic [31:0] pl_addr;
  logic [7:0]  pl_len;
  logic [1:0]  pl_pos;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ss_out_seq dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_page0(ld_page0),
    .ld_page1(ld_page1), .ld_offset(ld_offset), .ld_psel(ld_psel),
    .ld_pos(ld_pos), .ld_count(ld_count), .ld_bytes(ld_bytes),
    .ld_err(ld_err), .pl_req(pl_req), .pl_addr(pl_addr), .pl_len(pl_len),
    .pl_pos(pl_pos), .pl_ack(pl_ack), .retire(retire), .cross_err(cross_err)
  );

  // behavioural reference model
  bit        m_act, m_ps, m_ret, m_lerr, m_xerr;
  bit [19:0] m_p0, m_p1;
  int        m_off, m_pos, m_cnt, m_rem;
  int        pos_log[$];

  function automatic int mlen();
    return (m_rem > 188) ? 188 : m_rem;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act <= 0; m_ps <= 0; m_p0 <= 0; m_p1 <= 0; m_off <= 0;
      m_pos <= 0; m_cnt <= 0; m_rem <= 0;
      m_ret <= 0; m_lerr <= 0; m_xerr <= 0;
    end else begin
      m_ret <= 0; m_lerr <= 0; m_xerr <= 0;
      if (ld_valid) begin
        if (ld_count >= 1 && ld_count <= 6) begin
          m_act <= 1; m_p0 <= ld_page0; m_p1 <= ld_page1;
          m_off <= int'(ld_offset); m_ps <= ld_psel; m_pos <= int'(ld_pos);
          m_cnt <= int'(ld_count); m_rem <= int'(ld_bytes);
        end else m_lerr <= 1;
      end else if (m_act && pl_ack) begin
        pos_log.push_back(m_pos);
        if (m_ps && (m_off + mlen() >= 4096)) begin
          m_act <= 0; m_xerr <= 1;
        end else begin
          if (m_off + mlen() >= 4096) begin
            m_ps <= 1; m_off <= m_off + mlen() - 4096;
          end else m_off <= m_off + mlen();
          m_rem <= m_rem - mlen();
          m_cnt <= m_cnt - 1;
          m_pos <= (m_cnt == 2) ? 3 : 2;
          if (m_cnt == 1) begin m_act <= 0; m_ret <= 1; end
        end
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        // R10 reset state
        check(pl_req == 0 && ld_err == 0 && retire == 0 && cross_err == 0,
              "R10 flags", {pl_req, ld_err, retire, cross_err}, 0);
        check(pl_addr == 0, "R10 addr", pl_addr, 0);
      end else begin
        check(pl_req == m_act, "R1 pl_req", pl_req, m_act);
        check(ld_err == m_lerr, "R6 ld_err", ld_err, m_lerr);
        check(retire == m_ret, "R8 retire", retire, m_ret);
        check(cross_err == m_xerr, "R9 cross_err", cross_err, m_xerr);
        if (m_act) begin
          check(pl_addr == {(m_ps ? m_p1 : m_p0), 12'(m_off)}, "R2/R4 pl_addr",
                pl_addr, {(m_ps ? m_p1 : m_p0), 12'(m_off)});
          check(int'(pl_len) == mlen(), "R3 pl_len", pl_len, mlen());
          check(int'(pl_pos) == m_pos, "R7 pl_pos", pl_pos, m_pos);
        end
      end
    end
  end

  task automatic load(bit [19:0] p0, bit [19:0] p1, bit [11:0] off, bit ps,
                      bit [1:0] pos, bit [2:0] cnt, bit [10:0] bytes);
    @(posedge clk); #1;
    ld_valid = 1; ld_page0 = p0; ld_page1 = p1; ld_offset = off;
    ld_psel = ps; ld_pos = pos; ld_count = cnt; ld_bytes = bytes;
    @(posedge clk); #1;
    ld_valid = 0;
  endtask

  task automatic ack();
    @(posedge clk); #1 pl_ack = 1;
    @(posedge clk); #1 pl_ack = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1/R8: single all-payload transfer
    load(20'h12345, 20'h6789A, 12'h010, 0, 2'b00, 3'd1, 11'd100);
    idle(2); ack(); idle(2);
    // R4/R5/R7: three payloads crossing into page 1
    load(20'hAAAAA, 20'h55555, 12'hF80, 0, 2'b01, 3'd3, 11'd500);
    ack(); idle(1); ack(); ack(); idle(2);
    // R4: sum exactly 4096 lands on offset 0 of page 1
    load(20'h00F00, 20'h0F000, 12'hF44, 0, 2'b01, 3'd2, 11'd300);
    ack(); ack(); idle(2);
    // R6: refused loads, idle and during a transfer
    load(20'h1, 20'h2, 12'h0, 0, 2'b00, 3'd7, 11'd50);
    load(20'h1, 20'h2, 12'h0, 0, 2'b00, 3'd0, 11'd50);
    load(20'hBEEF0, 20'hCAFE0, 12'h200, 0, 2'b01, 3'd2, 11'd250);
    load(20'h1, 20'h2, 12'h0, 1, 2'b11, 3'd7, 11'd9);
    ack(); ack(); idle(2);
    // R9: second crossing aborts
    load(20'h11111, 20'h22222, 12'hFF0, 1, 2'b01, 3'd2, 11'd300);
    ack(); idle(2); ack(); idle(1);
    // R11: idle acks, then load together with ack
    ack(); ack();
    load(20'h33333, 20'h44444, 12'h020, 0, 2'b01, 3'd3, 11'd400);
    @(posedge clk); #1 ld_valid = 1; pl_ack = 1; ld_count = 3'd2; ld_bytes = 11'd200;
    @(posedge clk); #1 ld_valid = 0; pl_ack = 0;
    ack(); ack(); idle(2);
    // R5/R7: six start-splits
    load(20'h77777, 20'h88888, 12'h100, 0, 2'b01, 3'd6, 11'd1100);
    for (int i = 0; i < 6; i++) begin ack(); idle(i % 2); end
    idle(3);
    checks++;
    if (pos_log.size() < 6 || pos_log[pos_log.size()-1] != 3 ||
        pos_log[pos_log.size()-6] != 1) begin
      fails++;
      $display("FAIL R7 position order actual_size=%0d expected_end=3", pos_log.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule